// File: doc/BRIEF.md
# Pipelined Binary-to-Residue Converter

This block takes an unsigned binary word and produces its remainder modulo a fixed odd modulus between 17 and 31. It uses no lookup memory. The word is cut into 2-bit slices, starting at the least significant bit. Small per-slice logic maps each slice straight to the remainder of its weighted value. A carry-save adder tree adds all those small remainders into a redundant pair of vectors. A folding stage brings that pair below twice the modulus. A final compare-and-subtract stage yields the residue.

The block accepts one word per clock and delivers one residue per clock after a fixed latency. It sits in front of residue-arithmetic datapaths, where each operand has to be converted at full rate. Input and output each carry a valid flag. Idle cycles pass through the pipeline unchanged.

Top module: `bin2res_pipe`

## Requirements
- R1: For every word accepted with `inValid` high, `outRes` equals the word modulo `MOD` when its `outValid` appears.
- R2: A word sampled on rising edge t appears on the outputs right after rising edge t+3. Words on consecutive cycles come out on consecutive cycles, so one word is accepted every clock.
- R3: `outValid` is high exactly for the cycles that carry a word. Idle input cycles give idle output cycles, in the same order.
- R4: When `rst` is high at a rising edge, every word in flight is discarded. `outValid` stays low while `rst` is high and during the cycles after it, until new words arrive. Words presented while `rst` is high are not accepted.
- R5: A word whose only nonzero 2-bit slice is slice i, holding value s (1, 2 or 3), converts to (s·4^i) mod `MOD`. Slice i covers bits 2i+1:2i.
- R6: `outRes` is always below `MOD`. This holds for the corner words: all-zero, all-ones, exact multiples of `MOD`, and `MOD`−1. Inside the pipeline, the folded value stays below 2·`MOD`.
- R7: While `outValid` is low, `outRes` keeps the last residue it delivered.
- R8: The modulus is a parameter. Any odd value from 17 to 31 gives correct residues, shown here with 17. The default is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Input word present this cycle |
| inData | input | IN_W | Unsigned input word |
| outValid | output | 1 | Residue present this cycle |
| outRes | output | 5 | Residue of the word, below MOD |

## Verification
Properties are checked on every cycle:
- the residue matches the word taken four edges earlier;
- each slice remainder is below the modulus;
- the folded value is below twice the modulus;
- the output holds between words;
- an output valid always traces back to an input valid;
- the pipeline is empty after reset.

The bench's scenarios are needed for the rest:
- the exact three-edge output timing under back-to-back and bubbled traffic;
- the per-slice weights swept one slice at a time;
- the corner words;
- discarding words in flight when reset lands mid-stream;
- a second instance built with modulus 17.

// File: rtl/b2r_pkg.sv
package b2r_pkg;
  localparam int RES_W = 5;  // residue width for any modulus below 32
  localparam int RED_W = 6;  // width that holds a value below 2*MOD

  typedef struct packed {
    logic segLd;   // capture slice remainders
    logic csaLd;   // capture carry-save pair
    logic foldLd;  // capture folded value
    logic outLd;   // capture final residue
  } b2r_strobe_t;

  function automatic int unsigned pow2Mod(input int unsigned k, input int unsigned m);
    int unsigned r;
    r = 1 % m;
    for (int unsigned i = 0; i < k; i++) r = (r * 2) % m;
    return r;
  endfunction

  function automatic int unsigned sliceWeightRes(input int unsigned idx, input int unsigned s,
                                                 input int unsigned m);
    return (s * pow2Mod(2 * idx, m)) % m;
  endfunction
endpackage

// File: rtl/b2r_seg_gen.sv
module b2r_seg_gen
  import b2r_pkg::*;
#(
  parameter int SEG_IDX = 0,
  parameter int MOD     = 31
) (
  input  logic [1:0]       segVal,
  output logic [RES_W-1:0] segRes
);
  localparam logic [RES_W-1:0] C1 = RES_W'(sliceWeightRes(SEG_IDX, 1, MOD));
  localparam logic [RES_W-1:0] C2 = RES_W'(sliceWeightRes(SEG_IDX, 2, MOD));
  localparam logic [RES_W-1:0] C3 = RES_W'(sliceWeightRes(SEG_IDX, 3, MOD));

  always_comb begin
    case (segVal)
      2'd0:    segRes = '0;
      2'd1:    segRes = C1;
      2'd2:    segRes = C2;
      default: segRes = C3;
    endcase
  end
endmodule

// File: rtl/b2r_csa_tree.sv
module b2r_csa_tree
  import b2r_pkg::*;
#(
  parameter int NOPS  = 16,
  parameter int SUM_W = 10
) (
  input  logic [NOPS*RES_W-1:0] opsFlat,
  output logic [SUM_W-1:0]      sumVec,
  output logic [SUM_W-1:0]      carryVec
);
  localparam int NARR = (NOPS < 2) ? 2 : NOPS;

  logic [SUM_W-1:0] work [NARR];
  logic [SUM_W-1:0] nxt  [NARR];
  int cnt;
  int nc;

  always_comb begin
    for (int j = 0; j < NARR; j++) begin
      work[j] = '0;
      nxt[j]  = '0;
      if (j < NOPS) work[j] = SUM_W'(opsFlat[j*RES_W +: RES_W]);
    end
    cnt = NOPS;
    nc  = 0;
    // each level compresses groups of three rows into two
    for (int lvl = 0; lvl < NARR; lvl++) begin
      if (cnt > 2) begin
        for (int j = 0; j < NARR; j++) nxt[j] = '0;
        nc = 0;
        for (int j = 0; j < NARR; j += 3) begin
          if (j + 2 < cnt) begin
            nxt[nc]     = work[j] ^ work[j+1] ^ work[j+2];
            nxt[nc + 1] = ((work[j] & work[j+1]) | (work[j] & work[j+2]) |
                           (work[j+1] & work[j+2])) << 1;
            nc = nc + 2;
          end else if (j + 1 < cnt) begin
            nxt[nc]     = work[j];
            nxt[nc + 1] = work[j+1];
            nc = nc + 2;
          end else if (j < cnt) begin
            nxt[nc] = work[j];
            nc = nc + 1;
          end
        end
        for (int j = 0; j < NARR; j++) work[j] = nxt[j];
        cnt = nc;
      end
    end
    sumVec   = work[0];
    carryVec = work[1];
  end
endmodule

// File: rtl/b2r_fold.sv
module b2r_fold
  import b2r_pkg::*;
#(
  parameter int SUM_W = 10,
  parameter int MOD   = 31
) (
  input  logic [SUM_W-1:0] sumVec,
  input  logic [SUM_W-1:0] carryVec,
  output logic [RED_W-1:0] redVal
);
  logic [SUM_W-1:0] v;
  logic [SUM_W-1:0] nv;

  always_comb begin
    v  = sumVec + carryVec;  // true total fits SUM_W bits
    nv = '0;
    // replace every bit at or above RES_W by its weight mod MOD
    for (int it = 0; it < SUM_W; it++) begin
      nv = SUM_W'(v[RES_W-1:0]);
      for (int k = RES_W; k < SUM_W; k++) begin
        if (v[k]) nv = nv + SUM_W'(pow2Mod(k, MOD));
      end
      v = nv;
    end
    redVal = RED_W'(v);
  end
endmodule

// File: rtl/b2r_ctrl.sv
module b2r_ctrl
  import b2r_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output b2r_strobe_t strb,
  output logic        outValid
);
  localparam int LAT = 4;

  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strb.segLd  = inValid      & ~rst;
    strb.csaLd  = validPipe[0] & ~rst;
    strb.foldLd = validPipe[1] & ~rst;
    strb.outLd  = validPipe[2] & ~rst;
  end

  assign outValid = validPipe[LAT-1];

  p_valid_src_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 4));

  p_reset_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);
endmodule

// File: rtl/b2r_datapath.sv
module b2r_datapath
  import b2r_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int MOD  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  b2r_strobe_t      strb,
  input  logic [IN_W-1:0]  inData,
  output logic [RES_W-1:0] outRes
);
  localparam int NSEG  = (IN_W + 1) / 2;
  localparam int PAD_W = 2 * NSEG;
  localparam int SUM_W = RES_W + $clog2(NSEG + 1);

  logic [PAD_W-1:0]      padded;
  logic [NSEG*RES_W-1:0] segResFlat;
  logic [NSEG*RES_W-1:0] segReg;
  logic [SUM_W-1:0]      sumVec, carryVec, sumReg, carryReg;
  logic [RED_W-1:0]      redVal, foldReg;
  logic [RED_W:0]        diff;
  logic [RES_W-1:0]      finalRes;

  assign padded = PAD_W'(inData);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    b2r_seg_gen #(.SEG_IDX(g), .MOD(MOD)) u_seg (
      .segVal(padded[2*g +: 2]),
      .segRes(segResFlat[g*RES_W +: RES_W])
    );

    p_seg_range_r5: assert property (@(posedge clk) disable iff (rst)
      strb.csaLd |-> (int'(segReg[g*RES_W +: RES_W]) < MOD));
  end

  b2r_csa_tree #(.NOPS(NSEG), .SUM_W(SUM_W)) u_tree (
    .opsFlat (segReg),
    .sumVec  (sumVec),
    .carryVec(carryVec)
  );

  b2r_fold #(.SUM_W(SUM_W), .MOD(MOD)) u_fold (
    .sumVec  (sumReg),
    .carryVec(carryReg),
    .redVal  (redVal)
  );

  // value below 2*MOD: one conditional subtraction finishes it
  always_comb begin
    diff     = {1'b0, foldReg} - (RED_W+1)'(MOD);
    finalRes = diff[RED_W] ? foldReg[RES_W-1:0] : diff[RES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.segLd)  segReg   <= segResFlat;
    if (strb.csaLd)  sumReg   <= sumVec;
    if (strb.csaLd)  carryReg <= carryVec;
    if (strb.foldLd) foldReg  <= redVal;
    if (strb.outLd)  outRes   <= finalRes;
  end

  p_fold_range_r6: assert property (@(posedge clk) disable iff (rst)
    strb.outLd |-> (int'(foldReg) < 2 * MOD));

  p_out_range_r6: assert property (@(posedge clk) disable iff (rst)
    strb.outLd |=> (int'(outRes) < MOD));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.outLd |=> $stable(outRes));
endmodule

// File: rtl/bin2res_pipe.sv
module bin2res_pipe
  import b2r_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int MOD  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [RES_W-1:0] outRes
);
  b2r_strobe_t strb;

  initial begin
    p_mod_legal_r8: assert ((MOD % 2 == 1) && (MOD >= 17) && (MOD <= 31) && (IN_W >= RES_W));
  end

  b2r_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strb    (strb),
    .outValid(outValid)
  );

  b2r_datapath #(.IN_W(IN_W), .MOD(MOD)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .inData(inData),
    .outRes(outRes)
  );

  p_residue_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (($past(inData, 4) % IN_W'(MOD)) == IN_W'(outRes)));
endmodule

// File: tb/bin2res_pipe_bench.sv
`timescale 1ns/1ps
module bin2res_pipe_bench;
  localparam int IN_W = 32;

  logic clk = 0;
  logic rst = 1;
  logic inValid = 0;
  logic [IN_W-1:0] inData = '0;
  logic outValidA, outValidB;
  logic [4:0] outResA, outResB;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string curReq = "R4";
  int unsigned qResA[$];
  int unsigned qResB[$];
  int qCycA[$];
  int qCycB[$];
  bit seenA = 0, seenB = 0;
  logic [4:0] lastA = '0, lastB = '0;
  logic [31:0] lfsr = 32'h1;

  always #2 clk = ~clk;  // 250 MHz

  bin2res_pipe #(.IN_W(IN_W)) u_bin2res_pipe (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValidA), .outRes(outResA)
  );

  bin2res_pipe #(.IN_W(IN_W), .MOD(17)) u_bin2res_pipe_m17 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValidB), .outRes(outResB)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: words are stamped with the edge that samples them
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      qResA.delete(); qCycA.delete();
      qResB.delete(); qCycB.delete();
    end else if (inValid) begin
      qResA.push_back(int'(inData % 32'd31)); qCycA.push_back(cyc);
      qResB.push_back(int'(inData % 32'd17)); qCycB.push_back(cyc);
    end
  end

  always @(negedge clk) begin
    if (outValidA) begin
      if (qResA.size() == 0) check(0, curReq, "m31 unexpected valid (R3)", 1, 0);
      else begin
        int c;
        int unsigned r;
        c = qCycA.pop_front();
        r = qResA.pop_front();
        check(cyc == c + 3, "R2", "m31 latency", cyc - c, 3);
        check(outResA == r, curReq, "m31 residue", outResA, r);
        lastA = outResA;
        seenA = 1;
      end
    end else begin
      if (qCycA.size() > 0 && qCycA[0] + 3 <= cyc) begin
        check(0, "R3", "m31 missing valid", 0, 1);
        void'(qCycA.pop_front());
        void'(qResA.pop_front());
      end
      if (seenA) check(outResA == lastA, "R7", "m31 hold while idle", outResA, lastA);
    end

    if (outValidB) begin
      if (qResB.size() == 0) check(0, curReq, "m17 unexpected valid (R3)", 1, 0);
      else begin
        int c;
        int unsigned r;
        c = qCycB.pop_front();
        r = qResB.pop_front();
        check(cyc == c + 3, "R2", "m17 latency", cyc - c, 3);
        check(outResB == r, "R8", "m17 residue", outResB, r);
        lastB = outResB;
        seenB = 1;
      end
    end else begin
      if (qCycB.size() > 0 && qCycB[0] + 3 <= cyc) begin
        check(0, "R3", "m17 missing valid", 0, 1);
        void'(qCycB.pop_front());
        void'(qResB.pop_front());
      end
      if (seenB) check(outResB == lastB, "R7", "m17 hold while idle", outResB, lastB);
    end
  end

  task automatic send(input logic [IN_W-1:0] d);
    inValid = 1;
    inData  = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      inValid = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValidA && !outValidB, "R4", "valid during reset", outValidA, 0);
    rst = 0;
    idle(2);

    // R5: one nonzero slice at a time, back to back (R2)
    curReq = "R5";
    for (int seg = 0; seg < IN_W / 2; seg++)
      for (int s = 1; s < 4; s++)
        send(IN_W'(s) << (2 * seg));
    idle(5);

    // R6: corner words
    curReq = "R6";
    send('1);
    send('0);
    send(32'd31 * 32'd1000);
    send(32'd30);
    send(32'd16);
    send(32'hFFFF_FFFE);
    send(32'd31 * 32'd138547332);
    send(32'd17 * 32'd999);
    idle(5);

    // R1 with bubbles (R3)
    curReq = "R1";
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[0] | lfsr[3]) send(lfsr * 32'd2654435761);
      else idle(1);
    end
    idle(5);

    // R4: reset with words in flight
    curReq = "R4";
    send(32'h1234_5678);
    send(32'hDEAD_BEEF);
    inValid = 1;
    inData  = 32'h0BAD_F00D;
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(!outValidA && !outValidB, "R4", "valid while reset held", outValidA, 0);
    inValid = 0;
    rst = 0;
    idle(6);
    check(!outValidA && !outValidB, "R4", "pipeline empty after reset", outValidA, 0);

    curReq = "R1";
    send(32'd12345);
    send(32'd67890);
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule